// File: doc/BRIEF.md
# Serial Flow-Control Unit

This block is the per-channel flow-control engine of a UART. It does not serialize anything. It decides, one character at a time, whether the transmitter may start the next queued data character. It also raises a request to insert a flow-control character ahead of queued data, and it drives the RTS and DTR handshake outputs.

In-band control works on received characters. Each character is compared against two programmable codes, a resume code and a stop code. A stop code halts queued data transmission without any host action. A resume code releases the halt. Both codes are removed from the stream pushed into the receive FIFO.

The host can command a resume or stop character to throttle the remote end. Out-of-band control works through the handshake lines:
- RTS is raised while the channel has something to send.
- CTS is synchronized and must grant permission before a character starts.
- DTR follows the receive FIFO level against a programmable threshold.

In-band and out-of-band modes are enabled independently.

Top module: `flow_ctl_unit`

## Requirements
- R1: With in-band mode enabled, a received character equal to the stop code sets the halt state from the next cycle, and a character equal to the resume code clears it. If both codes are equal, the stop meaning wins. While halted, `tx_en_o` stays low.
- R2: With in-band mode enabled, a received character matching either code does not raise `rx_push_o`. Every other character is pushed in the same cycle with its byte on `rx_push_data_o`. With in-band mode disabled, every character is pushed and the halt state is cleared on the next clock.
- R3: A `cmd_xon_i` or `cmd_xoff_i` pulse makes a special character pending from the next cycle. `spec_code_o` shows the resume or stop code, and stop wins if both are pulsed together. The pending state lasts until `spec_ack_i` is sampled high in a cycle without a new command.
- R4: While a special character is pending, `tx_en_o` stays low. `spec_req_o` may rise even while data transmission is halted by a received stop code.
- R5: With out-of-band mode enabled, `tx_en_o` and `spec_req_o` also require CTS after a two-stage synchronizer, so CTS takes effect two clocks after it changes. With out-of-band mode disabled, CTS is ignored.
- R6: While `tx_busy_i` is high, neither `tx_en_o` nor `spec_req_o` is raised. CTS therefore only gates character starts, and a character in progress is never cut.
- R7: `rts_o` is registered. It is high in the cycle after out-of-band mode is enabled and there is queued data, a pending special character or a busy transmitter. Otherwise it is low.
- R8: `dtr_o` is registered. With out-of-band mode enabled it is low in the cycle after the FIFO level is at or above the threshold, and high otherwise. With out-of-band mode disabled it is high.
- R9: During reset: no halt, no pending special character, CTS synchronizer cleared, `rts_o` low, `dtr_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| inband_en_i | input | 1 | Enable for in-band resume/stop handling |
| oob_en_i | input | 1 | Enable for RTS/CTS/DTR handling |
| xon_code_i | input | 8 | Resume code |
| xoff_code_i | input | 8 | Stop code |
| rx_valid_i | input | 1 | Received-character strobe |
| rx_data_i | input | 8 | Received character |
| rx_push_o | output | 1 | Push received character into the receive FIFO |
| rx_push_data_o | output | 8 | Character to push |
| fifo_level_i | input | 4 | Receive FIFO fill level |
| dtr_thresh_i | input | 4 | Level at which DTR is dropped |
| cts_i | input | 1 | Clear-to-send, asynchronous |
| cmd_xon_i | input | 1 | Host command: send resume code |
| cmd_xoff_i | input | 1 | Host command: send stop code |
| tx_pending_i | input | 1 | Data character queued for transmission |
| tx_busy_i | input | 1 | Serializer is sending a character |
| tx_en_o | output | 1 | Serializer may start the queued data character |
| spec_req_o | output | 1 | Serializer may start the special character |
| spec_code_o | output | 8 | Special character to send |
| spec_ack_i | input | 1 | Serializer took the special character |
| rts_o | output | 1 | Request-to-send |
| dtr_o | output | 1 | Data-terminal-ready |

## Verification
The receive path is driven with three kinds of characters: ordinary bytes, the stop code and the resume code. This separates character filtering from halt control, and a run with equal codes checks which meaning wins. Special-character commands are issued in three situations: while halted, together with queued data, and with both commands in the same cycle. These show that insertion takes priority and does not depend on the halt. CTS is toggled while the serializer is both idle and busy, in both out-of-band settings, which checks the synchronizer delay and the rule that CTS is only sampled at character starts. The FIFO level is stepped across the threshold to check both DTR edges.

// File: rtl/fc_pkg.sv
package fc_pkg;
  typedef enum logic {SPEC_XON = 1'b0, SPEC_XOFF = 1'b1} spec_sel_e;
endpackage

// File: rtl/fc_inband.sv
module fc_inband #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DATA_W-1:0] xon_i,
  input  logic [DATA_W-1:0] xoff_i,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  output logic              halted_o,
  output logic              rx_push_o,
  output logic [DATA_W-1:0] rx_push_data_o
);
  logic hit_xon, hit_xoff, halted_q;

  assign hit_xon  = rx_valid_i && (rx_data_i == xon_i);
  assign hit_xoff = rx_valid_i && (rx_data_i == xoff_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       halted_q <= 1'b0;
    else if (!en_i)    halted_q <= 1'b0;
    else if (hit_xoff) halted_q <= 1'b1;
    else if (hit_xon)  halted_q <= 1'b0;
  end

  assign halted_o       = halted_q;
  assign rx_push_o      = rx_valid_i && !(en_i && (hit_xon || hit_xoff));
  assign rx_push_data_o = rx_data_i;

  // R1
  xoff_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && rx_valid_i && rx_data_i == xoff_i |=> halted_o);
  // R1
  xon_resume_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && rx_valid_i && rx_data_i == xon_i && rx_data_i != xoff_i |=> !halted_o);
  // R2
  off_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !halted_o);
endmodule

// File: rtl/fc_special.sv
module fc_special #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_xon_i,
  input  logic              cmd_xoff_i,
  input  logic              ack_i,
  input  logic [DATA_W-1:0] xon_i,
  input  logic [DATA_W-1:0] xoff_i,
  output logic              pend_o,
  output logic [DATA_W-1:0] code_o
);
  import fc_pkg::*;

  logic      pend_q;
  spec_sel_e sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      sel_q  <= SPEC_XON;
    end else if (cmd_xon_i || cmd_xoff_i) begin
      pend_q <= 1'b1;
      sel_q  <= cmd_xoff_i ? SPEC_XOFF : SPEC_XON;
    end else if (ack_i) begin
      pend_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;
  assign code_o = (sel_q == SPEC_XOFF) ? xoff_i : xon_i;

  // R3
  ack_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && !cmd_xon_i && !cmd_xoff_i |=> !pend_o);
  // R3
  xoff_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_xoff_i |=> pend_o && sel_q == SPEC_XOFF);
endmodule

// File: rtl/fc_oob.sv
module fc_oob #(
  parameter int LVL_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             cts_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic [LVL_W-1:0] thresh_i,
  input  logic             want_send_i,
  output logic             cts_ok_o,
  output logic             rts_o,
  output logic             dtr_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic rts_q, dtr_q;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= cts_i;
    end else begin : g_syncn
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], cts_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rts_q <= 1'b0;
      dtr_q <= 1'b1;
    end else begin
      rts_q <= en_i && want_send_i;
      dtr_q <= !(en_i && (level_i >= thresh_i));
    end
  end

  assign cts_ok_o = !en_i || sync_q[SYNC_STAGES-1];
  assign rts_o    = rts_q;
  assign dtr_o    = dtr_q;

  // R8
  dtr_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && level_i >= thresh_i |=> !dtr_o);
  // R8
  dtr_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i || level_i < thresh_i) |=> dtr_o);
  // R7
  rts_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !rts_o);
endmodule

// File: rtl/flow_ctl_unit.sv
module flow_ctl_unit #(
  parameter int DATA_W      = 8,
  parameter int LVL_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inband_en_i,
  input  logic              oob_en_i,
  input  logic [DATA_W-1:0] xon_code_i,
  input  logic [DATA_W-1:0] xoff_code_i,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  output logic              rx_push_o,
  output logic [DATA_W-1:0] rx_push_data_o,
  input  logic [LVL_W-1:0]  fifo_level_i,
  input  logic [LVL_W-1:0]  dtr_thresh_i,
  input  logic              cts_i,
  input  logic              cmd_xon_i,
  input  logic              cmd_xoff_i,
  input  logic              tx_pending_i,
  input  logic              tx_busy_i,
  output logic              tx_en_o,
  output logic              spec_req_o,
  output logic [DATA_W-1:0] spec_code_o,
  input  logic              spec_ack_i,
  output logic              rts_o,
  output logic              dtr_o
);
  logic halted, spec_pend, cts_ok, want_send;

  fc_inband #(.DATA_W(DATA_W)) u_inband (
    .clk_i, .rst_ni,
    .en_i(inband_en_i), .xon_i(xon_code_i), .xoff_i(xoff_code_i),
    .rx_valid_i, .rx_data_i,
    .halted_o(halted), .rx_push_o, .rx_push_data_o
  );

  fc_special #(.DATA_W(DATA_W)) u_special (
    .clk_i, .rst_ni,
    .cmd_xon_i, .cmd_xoff_i, .ack_i(spec_ack_i),
    .xon_i(xon_code_i), .xoff_i(xoff_code_i),
    .pend_o(spec_pend), .code_o(spec_code_o)
  );

  assign want_send = tx_pending_i || spec_pend || tx_busy_i;

  fc_oob #(.LVL_W(LVL_W), .SYNC_STAGES(SYNC_STAGES)) u_oob (
    .clk_i, .rst_ni,
    .en_i(oob_en_i), .cts_i, .level_i(fifo_level_i), .thresh_i(dtr_thresh_i),
    .want_send_i(want_send),
    .cts_ok_o(cts_ok), .rts_o, .dtr_o
  );

  // start decisions only at a character boundary
  assign spec_req_o = spec_pend && !tx_busy_i && cts_ok;
  assign tx_en_o    = tx_pending_i && !tx_busy_i && cts_ok && !spec_pend && !halted;

  // R6
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_busy_i |-> !tx_en_o && !spec_req_o);
  // R4
  spec_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spec_pend |-> !tx_en_o);
  // R1
  halt_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted |-> !tx_en_o);
  // R5
  cts_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oob_en_i && !cts_ok |-> !tx_en_o && !spec_req_o);
endmodule

// File: tb/sim_flow_ctl_unit.sv
module sim_flow_ctl_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic inband_en = 0, oob_en = 0, rx_valid = 0, cts = 0;
  logic cmd_xon = 0, cmd_xoff = 0, tx_pending = 0, tx_busy = 0, spec_ack = 0;
  logic [7:0] xon_code = 8'h11, xoff_code = 8'h13, rx_data = 0;
  logic [3:0] level = 0, thresh = 4'd6;
  logic rx_push, tx_en, spec_req, rts, dtr;
  logic [7:0] rx_push_data, spec_code;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  flow_ctl_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .inband_en_i(inband_en), .oob_en_i(oob_en),
    .xon_code_i(xon_code), .xoff_code_i(xoff_code),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .rx_push_o(rx_push), .rx_push_data_o(rx_push_data),
    .fifo_level_i(level), .dtr_thresh_i(thresh), .cts_i(cts),
    .cmd_xon_i(cmd_xon), .cmd_xoff_i(cmd_xoff),
    .tx_pending_i(tx_pending), .tx_busy_i(tx_busy),
    .tx_en_o(tx_en), .spec_req_o(spec_req), .spec_code_o(spec_code),
    .spec_ack_i(spec_ack), .rts_o(rts), .dtr_o(dtr)
  );

  // reference model state
  bit m_halt, m_pend, m_stop, m_rts, m_dtr;
  bit m_cts[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_halt = 0; m_pend = 0; m_stop = 0; m_rts = 0; m_dtr = 1;
      m_cts = '{0, 0};
    end else begin
      m_rts = oob_en && (tx_pending || m_pend || tx_busy);
      m_dtr = !(oob_en && (int'(level) >= int'(thresh)));
      if (!inband_en) m_halt = 0;
      else if (rx_valid && rx_data == xoff_code) m_halt = 1;
      else if (rx_valid && rx_data == xon_code) m_halt = 0;
      if (cmd_xon || cmd_xoff) begin m_pend = 1; m_stop = cmd_xoff; end
      else if (spec_ack) m_pend = 0;
      m_cts.push_back(cts);
      void'(m_cts.pop_front());
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit ok, e_push;
      ok = !oob_en || m_cts[0];
      e_push = rx_valid && !(inband_en && (rx_data == xon_code || rx_data == xoff_code));
      chk("R1/R4/R5/R6 tx_en", tx_en, tx_pending && !tx_busy && ok && !m_pend && !m_halt);
      chk("R4/R5/R6 spec_req", spec_req, m_pend && !tx_busy && ok);
      if (m_pend) chk("R3 spec_code", spec_code, m_stop ? xoff_code : xon_code);
      chk("R2 rx_push", rx_push, e_push);
      if (e_push) chk("R2 rx_push_data", rx_push_data, rx_data);
      chk("R7 rts", rts, m_rts);
      chk("R8 dtr", dtr, m_dtr);
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic rx(logic [7:0] c);
    rx_valid = 1; rx_data = c; tick(); rx_valid = 0; rx_data = 8'h00;
  endtask

  initial begin
    #2;
    // R9 reset state
    tx_pending = 1; cmd_xoff = 0;
    #10;
    chk("R9 rts reset", rts, 0);
    chk("R9 dtr reset", dtr, 1);
    chk("R9 spec_req reset", spec_req, 0);
    chk("R9 tx_en reset", tx_en, 1);
    tx_pending = 0;
    @(negedge clk); rst_n = 1; tick();
    // R2 in-band off: codes pass through
    tx_pending = 1;
    rx(8'h13); rx(8'h41); tick(2);
    // R1/R2 in-band on
    inband_en = 1; tick();
    rx(8'h41); rx(8'h13); tick(3); rx(8'h42);
    // R4 special while halted
    cmd_xon = 1; tick(); cmd_xon = 0; tick(2);
    spec_ack = 1; tick(); spec_ack = 0; tick();
    rx(8'h11); tick(2);
    // R3 both commands, ack with new command
    cmd_xon = 1; cmd_xoff = 1; tick(); cmd_xon = 0; cmd_xoff = 0; tick();
    spec_ack = 1; cmd_xon = 1; tick(); cmd_xon = 0; tick();
    spec_ack = 1; tick(); spec_ack = 0; tick();
    // R2 disabling in-band clears halt
    rx(8'h13); tick(); inband_en = 0; tick(2); inband_en = 1;
    // R1 equal codes: stop wins
    xon_code = 8'h13; rx(8'h13); tick(2); xon_code = 8'h11; rx(8'h11); tick();
    // R5/R6/R7 out-of-band
    oob_en = 1; tick(3);
    cts = 1; tick(3);
    tx_busy = 1; cts = 0; tick(4);
    tx_busy = 0; tick(2);
    cts = 1; cmd_xoff = 1; tick(); cmd_xoff = 0; tick(2);
    tx_busy = 1; spec_ack = 1; tick(); spec_ack = 0; tick(2); tx_busy = 0;
    tx_pending = 0; tick(3);
    // R8 threshold sweep
    for (int l = 0; l < 10; l++) begin level = 4'(l); tick(); end
    for (int l = 9; l >= 0; l--) begin level = 4'(l); tick(); end
    level = 4'd8; tick(); oob_en = 0; tick(2);
    // R5 CTS ignored with out-of-band off
    tx_pending = 1; cts = 0; tick(3);
    // mixed pattern
    for (int i = 0; i < 40; i++) begin
      oob_en = i[2]; cts = i[0] ^ i[3]; tx_busy = (i % 5) == 0;
      cmd_xon = (i % 7) == 1; spec_ack = (i % 3) == 2;
      rx_valid = (i % 4) == 1; rx_data = i[1] ? 8'h13 : (i[4] ? 8'h11 : 8'h55);
      level = 4'(i % 11);
      tick();
    end
    rx_valid = 0; cmd_xon = 0; spec_ack = 0; tx_busy = 0;
    tick(3);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule